// File: doc/BRIEF.md
# Keyed Flash Program and Erase Sequencer

This block sits between a CPU bus and an on-chip flash array. Software controls it through three 16-bit registers (mode, clock setup, lock/status). A register write counts only when its upper byte carries the key value. Once the lock bit is clear and a mode bit is armed, an ordinary CPU write into the flash window becomes a command and is not stored. The command is one of three: a segment erase, a whole-array erase, or a word/byte program. The address of that write selects the segment or the word.

The operation time comes from a flash timing clock. That clock is one of three sources (the main clock or one of two tick inputs) divided by a programmable factor of 1 to 64. While an operation runs, the block raises busy. If the code that started the operation was itself running from flash, any instruction fetch from flash returns a jump-to-self opcode, so the CPU spins in place until the array is free again. When the operation completes, the block sends one strobe to the array. An erase strobe fills the segment or the whole array with ones. A program strobe writes the old word ANDed with the new data.

Top module: `flash_op_ctrl`

## Requirements
- R1: After reset the status register reads 0x0010 (lock bit 4 set, busy bit 0 clear, both violation flags clear), and the mode and clock registers read 0x0000.
- R2: A register write whose bits 15:8 are not 0xA5 changes no register and sets the sticky key-violation flag (status bit 5). A keyed status write with bit 5 set clears the flag.
- R3: The clock register holds the divider in bits 5:0 and the source in bits 7:6 (00 aux_tick, 01 or 11 main clock, 10 sub_tick). An operation consumes exactly N x (divider + 1) source ticks, where N is PROG_TICKS for a program and ERASE_TICKS for an erase.
- R4: While status bit 4 (lock) is set, a write into the flash window starts nothing: busy stays low and the array is unchanged.
- R5: With mode bit 1 set, a write anywhere in a segment erases that segment, and only that segment, to 0xFFFF. The segment is the write address with its low log2(SEG_BYTES) bits cleared.
- R6: With mode bit 2 set, a write anywhere in the window erases the whole array to 0xFFFF. This bit takes priority over mode bit 1.
- R7: With only mode bit 6 set, a write programs the addressed word to old AND data. A byte lane whose cpu_be bit is 0 is left unchanged.
- R8: busy and status bit 0 go high on the edge that accepts the command and drop on the edge that sends the array strobe.
- R9: If the last instruction fetch before the command was from flash, every flash fetch returns 0x3FFF while busy and real data afterwards. If that last fetch was from outside flash, fetches are not replaced.
- R10: A flash write while busy is ignored and sets the sticky access-violation flag (status bit 2). A keyed status write with bit 2 set clears the flag.
- R11: A flash write made while unlocked but with no mode bit set starts nothing and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, also a timing source |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_tick | input | 1 | Timing source enable, select 00 |
| sub_tick | input | 1 | Timing source enable, select 10 |
| cpu_req | input | 1 | Bus access valid this cycle |
| cpu_we | input | 1 | Access is a write |
| cpu_fetch | input | 1 | Read is an instruction fetch |
| cpu_be | input | 2 | Byte lanes for a flash program |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data (combinational) |
| busy | output | 1 | Operation in progress |
| fl_addr | output | FA_W | Array word address |
| fl_rdata | input | 16 | Array read data |
| fl_wr | output | 1 | Program strobe |
| fl_wdata | output | 16 | Program data |
| fl_erase | output | 1 | Erase strobe |
| fl_mass | output | 1 | Erase covers the whole array |

## Verification
Two events can land in the same narrow window: a running operation that is still counting ticks, and a new CPU access to the flash window. The bench sends a second flash write on the cycle right after the command, then reads status while the first operation is still counting. It expects 0x0005: busy and the access-violation flag both set, lock clear. After completion it checks that the second target word is untouched and the first one is programmed. The same window is used for fetches: flash fetches issued during busy must return the self-jump code, and a fetch issued after completion must return the stored word.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam logic [7:0] KEY = 8'hA5;

  // mode register bits
  localparam int MODE_SEG  = 1;
  localparam int MODE_MASS = 2;
  localparam int MODE_PROG = 6;

  // status register bits
  localparam int ST_BUSY = 0;
  localparam int ST_ACCV = 2;
  localparam int ST_LOCK = 4;
  localparam int ST_KEYV = 5;

  localparam logic [15:0] SELF_JUMP = 16'h3FFF;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_CLK  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SRC_AUX   = 2'd0,
    SRC_MAIN  = 2'd1,
    SRC_SUB   = 2'd2,
    SRC_MAIN2 = 2'd3
  } src_e;

  typedef struct packed {
    logic prog;
    logic mass;
    logic seg;
  } mode_t;
endpackage

// File: rtl/fc_regs.sv
module fc_regs
  import fc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  reg_sel_e    sel,
  input  logic [15:0] wdata,
  input  logic        busy,
  input  logic        acc_hit,
  output mode_t       mode,
  output logic [5:0]  div,
  output src_e        src,
  output logic        lock,
  output logic [15:0] rdata
);
  mode_t      mode_q, mode_d;
  logic [5:0] div_q, div_d;
  src_e       src_q, src_d;
  logic       lock_q, lock_d;
  logic       keyv_q, keyv_d;
  logic       accv_q, accv_d;
  logic       key_ok;
  logic       upd;

  assign key_ok = (wdata[15:8] == KEY);
  assign upd    = wr_en | acc_hit;

  always_comb begin
    mode_d = mode_q;
    div_d  = div_q;
    src_d  = src_q;
    lock_d = lock_q;
    keyv_d = keyv_q;
    accv_d = accv_q;
    if (wr_en && !key_ok) begin
      keyv_d = 1'b1;
    end else if (wr_en) begin
      case (sel)
        SEL_MODE: begin
          mode_d.prog = wdata[MODE_PROG];
          mode_d.mass = wdata[MODE_MASS];
          mode_d.seg  = wdata[MODE_SEG];
        end
        SEL_CLK: begin
          div_d = wdata[5:0];
          src_d = src_e'(wdata[7:6]);
        end
        SEL_STAT: begin
          lock_d = wdata[ST_LOCK];
          if (wdata[ST_KEYV]) keyv_d = 1'b0;
          if (wdata[ST_ACCV]) accv_d = 1'b0;
        end
        default: ;
      endcase
    end
    if (acc_hit) accv_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      div_q  <= '0;
      src_q  <= SRC_AUX;
      lock_q <= 1'b1;
      keyv_q <= 1'b0;
      accv_q <= 1'b0;
    end else if (upd) begin
      mode_q <= mode_d;
      div_q  <= div_d;
      src_q  <= src_d;
      lock_q <= lock_d;
      keyv_q <= keyv_d;
      accv_q <= accv_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_MODE: begin
        rdata[MODE_PROG] = mode_q.prog;
        rdata[MODE_MASS] = mode_q.mass;
        rdata[MODE_SEG]  = mode_q.seg;
      end
      SEL_CLK:  rdata[7:0] = {src_q, div_q};
      SEL_STAT: begin
        rdata[ST_BUSY] = busy;
        rdata[ST_ACCV] = accv_q;
        rdata[ST_LOCK] = lock_q;
        rdata[ST_KEYV] = keyv_q;
      end
      default: ;
    endcase
  end

  assign mode = mode_q;
  assign div  = div_q;
  assign src  = src_q;
  assign lock = lock_q;
endmodule

// File: rtl/fc_timegen.sv
module fc_timegen
  import fc_pkg::*;
#(
  parameter int ERASE_TICKS = 4819,
  parameter int PROG_TICKS  = 35
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       aux_tick,
  input  logic       sub_tick,
  input  src_e       src,
  input  logic [5:0] div,
  input  logic       start,
  input  logic       long_op,
  output logic       busy,
  output logic       done
);
  localparam int MAX_T = (ERASE_TICKS > PROG_TICKS) ? ERASE_TICKS : PROG_TICKS;
  localparam int CW    = $clog2(MAX_T + 1);

  logic [CW-1:0] cnt_q, cnt_d, last_q, last_d;
  logic [5:0]    dv_q, dv_d;
  logic          busy_q, busy_d;
  logic          src_tick, ftg_tick;

  always_comb begin
    case (src)
      SRC_AUX: src_tick = aux_tick;
      SRC_SUB: src_tick = sub_tick;
      default: src_tick = 1'b1;
    endcase
  end

  assign ftg_tick = busy_q & src_tick & (dv_q >= div);
  assign done     = ftg_tick & (cnt_q == last_q);

  always_comb begin
    cnt_d  = cnt_q;
    last_d = last_q;
    dv_d   = dv_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      dv_d   = '0;
      last_d = long_op ? CW'(ERASE_TICKS - 1) : CW'(PROG_TICKS - 1);
    end else if (busy_q && src_tick) begin
      if (dv_q >= div) begin
        dv_d = '0;
        if (cnt_q == last_q) busy_d = 1'b0;
        else                 cnt_d  = cnt_q + 1'b1;
      end else begin
        dv_d = dv_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= '0;
      dv_q   <= '0;
      busy_q <= 1'b0;
    end else if (start || busy_q) begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
      dv_q   <= dv_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
  import fc_pkg::*;
#(
  parameter logic [15:0] REG_BASE    = 16'h0140,
  parameter int          FLASH_BYTES = 4096,
  parameter int          SEG_BYTES   = 512,
  parameter int          ERASE_TICKS = 4819,
  parameter int          PROG_TICKS  = 35,
  localparam int         FA_W        = $clog2(FLASH_BYTES) - 1,
  localparam int         SEG_W       = $clog2(SEG_BYTES) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            aux_tick,
  input  logic            sub_tick,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic            cpu_fetch,
  input  logic [1:0]      cpu_be,
  input  logic [15:0]     cpu_addr,
  input  logic [15:0]     cpu_wdata,
  output logic [15:0]     cpu_rdata,
  output logic            busy,
  output logic [FA_W-1:0] fl_addr,
  input  logic [15:0]     fl_rdata,
  output logic            fl_wr,
  output logic [15:0]     fl_wdata,
  output logic            fl_erase,
  output logic            fl_mass
);
  logic [1:0] rs_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  logic        in_flash, reg_hit, wr_reg, wr_flash, start, acc_hit, long_op;
  logic        busy_i, done, lock, subst, addr_lsb_unused;
  reg_sel_e    sel;
  mode_t       mode;
  logic [5:0]  div;
  src_e        src;
  logic [15:0] reg_rd;

  assign addr_lsb_unused = cpu_addr[0];
  assign in_flash = &cpu_addr[15:FA_W+1];
  assign reg_hit  = (cpu_addr[15:3] == REG_BASE[15:3]) && (cpu_addr[2:1] != 2'd3);
  assign sel      = reg_sel_e'(cpu_addr[2:1]);
  assign wr_reg   = cpu_req & cpu_we & reg_hit;
  assign wr_flash = cpu_req & cpu_we & in_flash;
  assign start    = wr_flash & ~busy_i & ~lock & (mode.prog | mode.seg | mode.mass);
  assign acc_hit  = wr_flash & busy_i;
  assign long_op  = mode.seg | mode.mass;

  fc_regs u_regs (
    .clk(clk), .rst_n(rst_n_i), .wr_en(wr_reg), .sel(sel), .wdata(cpu_wdata),
    .busy(busy_i), .acc_hit(acc_hit), .mode(mode), .div(div), .src(src),
    .lock(lock), .rdata(reg_rd)
  );

  fc_timegen #(.ERASE_TICKS(ERASE_TICKS), .PROG_TICKS(PROG_TICKS)) u_tg (
    .clk(clk), .rst_n(rst_n_i), .aux_tick(aux_tick), .sub_tick(sub_tick),
    .src(src), .div(div), .start(start), .long_op(long_op),
    .busy(busy_i), .done(done)
  );

  // captured command
  logic [FA_W-1:0] op_addr_q, op_addr_d, tgt;
  logic [15:0]     op_data_q, op_data_d;
  logic            op_erase_q, op_erase_d, op_mass_q, op_mass_d;
  logic            op_ff_q, op_ff_d, last_fetch_q, last_fetch_d;

  always_comb begin
    op_addr_d    = cpu_addr[FA_W:1];
    op_data_d    = {cpu_be[1] ? cpu_wdata[15:8] : 8'hFF,
                    cpu_be[0] ? cpu_wdata[7:0]  : 8'hFF};
    op_erase_d   = mode.seg | mode.mass;
    op_mass_d    = mode.mass;
    op_ff_d      = last_fetch_q;
    last_fetch_d = in_flash;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      op_addr_q  <= '0;
      op_data_q  <= '0;
      op_erase_q <= 1'b0;
      op_mass_q  <= 1'b0;
      op_ff_q    <= 1'b0;
    end else if (start) begin
      op_addr_q  <= op_addr_d;
      op_data_q  <= op_data_d;
      op_erase_q <= op_erase_d;
      op_mass_q  <= op_mass_d;
      op_ff_q    <= op_ff_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)                 last_fetch_q <= 1'b0;
    else if (cpu_req && cpu_fetch) last_fetch_q <= last_fetch_d;
  end

  always_comb begin
    tgt = op_addr_q;
    if (op_mass_q)       tgt = '0;
    else if (op_erase_q) tgt[SEG_W-1:0] = '0;
  end

  assign fl_addr  = done ? tgt : cpu_addr[FA_W:1];
  assign fl_wr    = done & ~op_erase_q;
  assign fl_erase = done & op_erase_q;
  assign fl_mass  = done & op_mass_q;
  assign fl_wdata = fl_rdata & op_data_q;

  assign subst = cpu_req & cpu_fetch & in_flash & busy_i & op_ff_q;

  always_comb begin
    if (reg_hit)       cpu_rdata = reg_rd;
    else if (subst)    cpu_rdata = SELF_JUMP;
    else if (in_flash) cpu_rdata = fl_rdata;
    else               cpu_rdata = '0;
  end

  assign busy = busy_i;
endmodule

// File: rtl/fc_chk.sv
module fc_chk
  import fc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_reg,
  input logic       wr_flash,
  input logic [7:0] key_byte,
  input logic       lock,
  input logic       busy,
  input logic [2:0] mode_bits,
  input logic [7:0] clk_cfg,
  input logic       fl_wr,
  input logic       fl_erase,
  input logic       fl_mass
);
  // R2
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reg && key_byte != KEY) |=> ($stable(mode_bits) && $stable(clk_cfg)));

  // R4
  locked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flash && lock && !busy) |=> !busy);

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_flash));

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(fl_wr || fl_erase));

  // R8
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_wr || fl_erase) |-> busy);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_wr |-> !fl_erase);

  // R6
  mass_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_mass |-> fl_erase);
endmodule

bind flash_op_ctrl fc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_reg(wr_reg), .wr_flash(wr_flash),
  .key_byte(cpu_wdata[15:8]), .lock(lock), .busy(busy_i), .mode_bits(mode),
  .clk_cfg({src, div}), .fl_wr(fl_wr), .fl_erase(fl_erase), .fl_mass(fl_mass)
);

// File: tb/tb_flash_op_ctrl.sv
module tb_flash_op_ctrl;
  localparam int FB  = 4096;
  localparam int SEG = 512;
  localparam int ET  = 12;
  localparam int PT  = 3;
  localparam int NW  = FB / 2;
  localparam logic [15:0] RB     = 16'h0140;
  localparam logic [15:0] R_MODE = RB;
  localparam logic [15:0] R_CLK  = RB + 16'd2;
  localparam logic [15:0] R_STAT = RB + 16'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aux_tick, sub_tick;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_fetch = 1'b0;
  logic [1:0]  cpu_be = 2'b11;
  logic [15:0] cpu_addr = '0, cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        busy;
  logic [10:0] fl_addr;
  logic [15:0] fl_rdata, fl_wdata;
  logic        fl_wr, fl_erase, fl_mass;

  always #4 clk = ~clk;

  flash_op_ctrl #(.REG_BASE(RB), .FLASH_BYTES(FB), .SEG_BYTES(SEG),
                  .ERASE_TICKS(ET), .PROG_TICKS(PT)) dut (
    .clk(clk), .rst_n(rst_n), .aux_tick(aux_tick), .sub_tick(sub_tick),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_fetch(cpu_fetch), .cpu_be(cpu_be),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .busy(busy), .fl_addr(fl_addr), .fl_rdata(fl_rdata), .fl_wr(fl_wr),
    .fl_wdata(fl_wdata), .fl_erase(fl_erase), .fl_mass(fl_mass)
  );

  function automatic logic [15:0] iv(int i);
    return 16'(i * 263) ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] fa(int w);
    return 16'(16'hF000 + 2 * w);
  endfunction

  // behavioural array
  logic [15:0] mem [0:NW-1];
  initial for (int i = 0; i < NW; i++) mem[i] = iv(i);
  assign fl_rdata = mem[fl_addr];
  always @(posedge clk) begin
    if (fl_erase) begin
      if (fl_mass) for (int i = 0; i < NW; i++) mem[i] = 16'hFFFF;
      else for (int i = 0; i < SEG / 2; i++) mem[int'(fl_addr) + i] = 16'hFFFF;
    end
    if (fl_wr) mem[fl_addr] = fl_wdata;
  end

  // timing sources
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  assign aux_tick = (cyc % 3 == 0);
  assign sub_tick = (cyc % 4 == 1);

  int busy_cnt = 0, aux_cnt = 0, sub_cnt = 0;
  always @(negedge clk) if (busy) begin
    busy_cnt <= busy_cnt + 1;
    if (aux_tick) aux_cnt <= aux_cnt + 1;
    if (sub_tick) sub_cnt <= sub_cnt + 1;
  end

  // scoreboard
  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    logic [15:0] e;
    string t;
    if (cpu_req && !cpu_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read at %h with nothing expected, got %h expected none", cpu_addr, cpu_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (cpu_rdata !== e) begin
          errors++;
          $display("FAIL %s: addr %h got %h expected %h", t, cpu_addr, cpu_rdata, e);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_fetch = 1'b0;
    cpu_addr = a; cpu_wdata = d; cpu_be = be;
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_be = 2'b11;
  endtask

  task automatic rd(input logic [15:0] a, input logic f, input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_fetch = f; cpu_addr = a;
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_fetch = 1'b0;
  endtask

  task automatic wait_idle;
    while (busy) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    int b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    rd(R_STAT, 0, 16'h0010, "R1 status");
    rd(R_MODE, 0, 16'h0000, "R1 mode");
    rd(R_CLK,  0, 16'h0000, "R1 clock");
    chk("R1 busy", int'(busy), 0);

    // R2 key protection
    wr(R_MODE, 16'h1242);
    rd(R_MODE, 0, 16'h0000, "R2 mode kept");
    rd(R_STAT, 0, 16'h0030, "R2 flag set");
    wr(R_CLK, 16'h5A7F);
    rd(R_CLK, 0, 16'h0000, "R2 clock kept");
    wr(R_STAT, 16'hA530);
    rd(R_STAT, 0, 16'h0010, "R2 flag cleared");

    // setup: main clock / 2, unlock, program mode
    wr(R_CLK, 16'hA541);
    rd(R_CLK, 0, 16'h0041, "R3 clock field");
    wr(R_STAT, 16'hA500);
    rd(R_STAT, 0, 16'h0000, "R4 unlocked");
    wr(R_MODE, 16'hA540);
    rd(R_MODE, 0, 16'h0040, "R7 mode");

    // R7 word program, R8 busy, R3 length
    b = busy_cnt;
    wr(fa(1), 16'h00F0);
    rd(R_STAT, 0, 16'h0001, "R8 busy bit");
    wait_idle();
    chk("R3 busy length main/2", busy_cnt - b, PT * 2);
    rd(fa(1), 0, iv(1) & 16'h00F0, "R7 word program");

    // R7 byte lane
    wr(fa(2), 16'h0F0F, 2'b10);
    wait_idle();
    rd(fa(2), 0, iv(2) & 16'h0FFF, "R7 byte lane");

    // R9 fetch substitution
    rd(fa(8), 1, iv(8), "R9 fetch idle");
    wr(fa(3), 16'hFFFF);
    rd(fa(8), 1, 16'h3FFF, "R9 fetch replaced");
    rd(fa(9), 1, 16'h3FFF, "R9 fetch replaced other word");
    wait_idle();
    rd(fa(8), 1, iv(8), "R9 fetch resumed");
    rd(16'h0200, 1, 16'h0000, "R9 fetch outside");
    wr(fa(3), 16'hFFFF);
    rd(fa(8), 1, iv(8), "R9 no replacement after outside fetch");
    wait_idle();

    // R10 write while busy
    wr(fa(4), 16'h0000);
    wr(fa(5), 16'h0000);
    rd(R_STAT, 0, 16'h0005, "R10 flag while busy");
    wait_idle();
    rd(fa(5), 0, iv(5), "R10 second write ignored");
    rd(fa(4), 0, 16'h0000, "R7 program to zero");
    rd(R_STAT, 0, 16'h0004, "R10 flag sticky");
    wr(R_STAT, 16'hA504);
    rd(R_STAT, 0, 16'h0000, "R10 flag cleared");

    // R11 no mode armed
    wr(R_MODE, 16'hA500);
    wr(fa(6), 16'h0000);
    chk("R11 no busy", int'(busy), 0);
    rd(fa(6), 0, iv(6), "R11 array untouched");

    // R5 segment erase on aux source / 3
    wr(R_CLK, 16'hA502);
    wr(R_MODE, 16'hA502);
    b = aux_cnt;
    wr(16'hF234, 16'h0000);
    chk("R8 busy after command", int'(busy), 1);
    wait_idle();
    chk("R3 aux ticks", aux_cnt - b, ET * 3);
    rd(fa(256), 0, 16'hFFFF, "R5 segment first word");
    rd(fa(511), 0, 16'hFFFF, "R5 segment last word");
    rd(fa(255), 0, iv(255), "R5 segment below kept");
    rd(fa(512), 0, iv(512), "R5 segment above kept");

    // R6 mass erase with priority, main clock / 1
    wr(R_CLK, 16'hA540);
    wr(R_MODE, 16'hA506);
    b = busy_cnt;
    wr(fa(1000), 16'h1111);
    wait_idle();
    chk("R6 erase length", busy_cnt - b, ET);
    rd(fa(0), 0, 16'hFFFF, "R6 first word");
    rd(fa(700), 0, 16'hFFFF, "R6 middle word");
    rd(fa(1000), 0, 16'hFFFF, "R6 command word");
    rd(fa(NW - 1), 0, 16'hFFFF, "R6 last word");

    // R4 lock
    wr(R_STAT, 16'hA510);
    wr(R_MODE, 16'hA540);
    wr(fa(0), 16'h0000);
    chk("R4 no busy while locked", int'(busy), 0);
    rd(fa(0), 0, 16'hFFFF, "R4 array kept");
    rd(R_STAT, 0, 16'h0010, "R4 lock bit");

    // R3 sub source
    wr(R_STAT, 16'hA500);
    wr(R_CLK, 16'hA580);
    b = sub_cnt;
    wr(fa(0), 16'h1234);
    wait_idle();
    chk("R3 sub ticks", sub_cnt - b, PT);
    rd(fa(0), 0, 16'h1234, "R7 program from erased");

    repeat (2) @(posedge clk);
    #1;
    chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule